// File: doc/BRIEF.md
# Fused multiply-add special-operand resolver

This combinational block sits at the front of a double-precision fused multiply-add unit that computes z + x·y, or z − x·y when the negate-product control is set. It sorts each of the three operands into a class: zero, subnormal, normal, infinity, quiet NaN or signalling NaN. From those classes it decides whether the final result is already fixed without any arithmetic. When it is, it raises a bypass flag and supplies the finished 64-bit result, together with the invalid-operation flag.

When the bypass flag is low, the arithmetic datapath downstream owns the result and the bypass word is held at zero. The block resolves the special cases in a fixed order. NaN operands come first, signalling ahead of quiet. Next come an infinite product and an infinite addend. Last, a zero product decides the sign of the result from the rounding mode.

Top module: `fma_special_resolve`

## Requirements
- R1: If any operand is a signalling NaN (exponent all ones, fraction nonzero, fraction bit 51 clear), the block picks the first one in the order z, x, y. It returns that operand with fraction bit 51 set, and asserts both bypass and invalid.
- R2: If no operand is a signalling NaN but one is a quiet NaN (exponent all ones, fraction bit 51 set), the block returns the first quiet NaN in the order z, x, y unchanged. Bypass is asserted and invalid is not.
- R3: Without NaNs, an infinite x times a zero y, or a zero x times an infinite y, gives the default NaN 0x7FF8000000000000 with bypass and invalid.
- R4: The effective product sign is sign(x) XOR sign(y), inverted when the negate-product input is 1. This sign decides R5, R6, R8 and R9.
- R5: Without NaNs, if the product is infinite, not zero, and z is an infinity whose sign differs from the product sign, the result is the default NaN with invalid.
- R6: Without NaNs, if the product is infinite and R3 and R5 do not apply, the result is the infinity carrying the product sign, and invalid is not raised.
- R7: Without NaNs, if the product is finite and z is infinite, the result is z. Bypass is raised and invalid is not.
- R8: Without NaNs, if the product is zero and z is a zero with the same sign as the product, the result is z.
- R9: Without NaNs, if the product is zero and z is a zero of the opposite sign, the result is +0. It is −0 instead when the rounding-mode input is 2'b11 (round toward minus infinity).
- R10: Without NaNs, if the product is zero and z is finite and nonzero (normal or subnormal), the result is z without invalid.
- R11: If no operand is a NaN, x and y are both finite and nonzero, and z is finite, then bypass is 0, invalid is 0 and the result word is 0.
- R12: Invalid is never asserted while bypass is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_z | input | 64 | Addend operand, binary64 encoding |
| op_x | input | 64 | First multiplicand, binary64 encoding |
| op_y | input | 64 | Second multiplicand, binary64 encoding |
| neg_prod | input | 1 | 1 selects z − x·y, 0 selects z + x·y |
| rnd_mode | input | 2 | Rounding-mode code; 2'b11 is round toward minus infinity |
| byp_valid | output | 1 | Result fixed without arithmetic |
| byp_result | output | 64 | Fixed result when byp_valid is high, else zero |
| flag_invalid | output | 1 | Invalid-operation exception |

## Verification
The immediate assertions assume every input bit is a known 0 or 1, and that the inputs settle before anyone reads the outputs. The checks are only meaningful once the combinational cone has evaluated. The bench meets these assumptions: it drives every input from one task at the falling clock edge and compares a quarter period later. Its operand pool covers each sign of each of the six classes, including NaNs with nonzero payloads. It sweeps all of them as z, x and y under both values of the negate control and all four rounding codes. This way every precedence pairing and every sign combination of the infinity and zero rules is applied.

// File: rtl/fma_spec_pkg.sv
package fma_spec_pkg;

    localparam int EXP_W  = 11;
    localparam int FRAC_W = 52;
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int QBIT   = FRAC_W - 1;
    localparam int N_OPS  = 3;

    localparam logic [1:0] RM_DOWN = 2'b11;

    typedef enum logic [2:0] {
        CLS_ZERO = 3'd0,
        CLS_SUB  = 3'd1,
        CLS_NORM = 3'd2,
        CLS_INF  = 3'd3,
        CLS_QNAN = 3'd4,
        CLS_SNAN = 3'd5
    } opcls_e;

    typedef struct packed {
        logic   sign;
        opcls_e cls;
    } opinfo_t;

    typedef struct packed {
        logic              valid;
        logic              invalid;
        logic [WORD_W-1:0] word;
    } verdict_t;

    function automatic logic [WORD_W-1:0] dflt_nan();
        logic [WORD_W-1:0] w;
        w = '0;
        w[WORD_W-2 -: EXP_W] = '1;
        w[QBIT] = 1'b1;
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] inf_word(input logic s);
        logic [WORD_W-1:0] w;
        w = '0;
        w[WORD_W-1] = s;
        w[WORD_W-2 -: EXP_W] = '1;
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] zero_word(input logic s);
        logic [WORD_W-1:0] w;
        w = '0;
        w[WORD_W-1] = s;
        return w;
    endfunction

    function automatic logic is_nan_cls(input opcls_e c);
        return (c == CLS_QNAN) || (c == CLS_SNAN);
    endfunction

endpackage

// File: rtl/fsr_classify.sv
module fsr_classify
    import fma_spec_pkg::*;
#(
    parameter int E_W = EXP_W,
    parameter int F_W = FRAC_W
) (
    input  logic [E_W+F_W:0] word,
    output opinfo_t          info
);
    logic [E_W-1:0] expo;
    logic [F_W-1:0] frac;
    logic           exp_max;
    logic           exp_min;
    logic           frac_nz;

    assign expo    = word[E_W+F_W-1 -: E_W];
    assign frac    = word[F_W-1:0];
    assign exp_max = &expo;
    assign exp_min = ~|expo;
    assign frac_nz = |frac;

    always_comb begin
        info.sign = word[E_W+F_W];
        if (exp_max && !frac_nz)      info.cls = CLS_INF;
        else if (exp_max && frac[F_W-1]) info.cls = CLS_QNAN;
        else if (exp_max)             info.cls = CLS_SNAN;
        else if (exp_min && !frac_nz) info.cls = CLS_ZERO;
        else if (exp_min)             info.cls = CLS_SUB;
        else                          info.cls = CLS_NORM;
    end

    always_comb begin
        // R1
        snan_quietbit_chk: assert (!(info.cls == CLS_SNAN) || (!frac[F_W-1] && frac_nz));
    end
endmodule

// File: rtl/fsr_nan_pick.sv
module fsr_nan_pick
    import fma_spec_pkg::*;
#(
    parameter int W = WORD_W,
    parameter int N = N_OPS
) (
    input  opinfo_t        info  [N],
    input  logic [W-1:0]   words [N],
    output verdict_t       verdict
);
    logic [N-1:0] is_s;
    logic [N-1:0] is_q;

    for (genvar g = 0; g < N; g++) begin : g_flags
        assign is_s[g] = (info[g].cls == CLS_SNAN);
        assign is_q[g] = (info[g].cls == CLS_QNAN);
    end

    always_comb begin
        verdict = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (is_q[i] && !(|is_s)) begin
                verdict.valid   = 1'b1;
                verdict.invalid = 1'b0;
                verdict.word    = words[i];
            end
        end
        for (int i = N - 1; i >= 0; i--) begin
            if (is_s[i]) begin
                verdict.valid       = 1'b1;
                verdict.invalid     = 1'b1;
                verdict.word        = words[i];
                verdict.word[QBIT]  = 1'b1;
            end
        end
    end

    always_comb begin
        // R2
        qnan_silent_chk: assert (!(|is_q && !(|is_s)) || (verdict.valid && !verdict.invalid));
    end
endmodule

// File: rtl/fsr_case_solve.sv
module fsr_case_solve
    import fma_spec_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  opinfo_t      zi,
    input  opinfo_t      xi,
    input  opinfo_t      yi,
    input  logic [W-1:0] z_word,
    input  logic         neg_prod,
    input  logic [1:0]   rnd_mode,
    output verdict_t     verdict
);
    logic prod_sign;
    logic prod_inf;
    logic prod_zero;
    logic z_inf;
    logic z_zero;

    assign prod_sign = xi.sign ^ yi.sign ^ neg_prod;
    assign prod_inf  = (xi.cls == CLS_INF) || (yi.cls == CLS_INF);
    assign prod_zero = (xi.cls == CLS_ZERO) || (yi.cls == CLS_ZERO);
    assign z_inf     = (zi.cls == CLS_INF);
    assign z_zero    = (zi.cls == CLS_ZERO);

    always_comb begin
        verdict = '0;
        if (prod_inf && prod_zero) begin
            verdict.valid   = 1'b1;
            verdict.invalid = 1'b1;
            verdict.word    = dflt_nan();
        end else if (prod_inf) begin
            verdict.valid = 1'b1;
            if (z_inf && (zi.sign != prod_sign)) begin
                verdict.invalid = 1'b1;
                verdict.word    = dflt_nan();
            end else begin
                verdict.word    = inf_word(prod_sign);
            end
        end else if (z_inf) begin
            verdict.valid = 1'b1;
            verdict.word  = z_word;
        end else if (prod_zero) begin
            verdict.valid = 1'b1;
            if (z_zero && (zi.sign != prod_sign))
                verdict.word = zero_word(rnd_mode == RM_DOWN);
            else
                verdict.word = z_word;
        end
    end

    always_comb begin
        // R6
        inf_sign_chk: assert (!(prod_inf && !verdict.invalid) || (verdict.word[W-1] == prod_sign));
    end
endmodule

// File: rtl/fma_special_resolve.sv
module fma_special_resolve
    import fma_spec_pkg::*;
(
    input  logic [63:0] op_z,
    input  logic [63:0] op_x,
    input  logic [63:0] op_y,
    input  logic        neg_prod,
    input  logic [1:0]  rnd_mode,
    output logic        byp_valid,
    output logic [63:0] byp_result,
    output logic        flag_invalid
);
    logic [WORD_W-1:0] words [N_OPS];
    opinfo_t           info  [N_OPS];
    verdict_t          nan_v;
    verdict_t          rule_v;
    verdict_t          final_v;

    assign words[0] = op_z;
    assign words[1] = op_x;
    assign words[2] = op_y;

    for (genvar g = 0; g < N_OPS; g++) begin : g_cls
        fsr_classify #(.E_W(EXP_W), .F_W(FRAC_W)) u_cls (
            .word (words[g]),
            .info (info[g])
        );
    end

    fsr_nan_pick #(.W(WORD_W), .N(N_OPS)) u_nan (
        .info    (info),
        .words   (words),
        .verdict (nan_v)
    );

    fsr_case_solve #(.W(WORD_W)) u_rules (
        .zi       (info[0]),
        .xi       (info[1]),
        .yi       (info[2]),
        .z_word   (words[0]),
        .neg_prod (neg_prod),
        .rnd_mode (rnd_mode),
        .verdict  (rule_v)
    );

    assign final_v      = nan_v.valid ? nan_v : rule_v;
    assign byp_valid    = final_v.valid;
    assign byp_result   = final_v.word;
    assign flag_invalid = final_v.invalid;

    always_comb begin
        // R12
        inv_needs_bypass_chk: assert (!flag_invalid || byp_valid);
        // R3
        inf_times_zero_chk: assert (!((info[1].cls == CLS_INF) && (info[2].cls == CLS_ZERO)
                                      && !is_nan_cls(info[0].cls))
                                    || (flag_invalid && byp_result == dflt_nan()));
        // R11
        arith_path_chk: assert (!((info[0].cls inside {CLS_ZERO, CLS_SUB, CLS_NORM})
                                  && (info[1].cls inside {CLS_SUB, CLS_NORM})
                                  && (info[2].cls inside {CLS_SUB, CLS_NORM}))
                                || (!byp_valid && !flag_invalid && byp_result == '0));
        // R7
        z_inf_pass_chk: assert (!((info[0].cls == CLS_INF)
                                  && (info[1].cls inside {CLS_ZERO, CLS_SUB, CLS_NORM})
                                  && (info[2].cls inside {CLS_ZERO, CLS_SUB, CLS_NORM}))
                                || (byp_valid && byp_result == op_z && !flag_invalid));
    end
endmodule

// File: tb/fma_special_resolve_bench.sv
module fma_special_resolve_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N_VALS     = 12;
    localparam int WD_LIMIT   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] op_z, op_x, op_y;
    logic        neg_prod;
    logic [1:0]  rnd_mode;
    logic        byp_valid;
    logic [63:0] byp_result;
    logic        flag_invalid;

    int n_vec  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fma_special_resolve u_fma_special_resolve (
        .op_z(op_z), .op_x(op_x), .op_y(op_y),
        .neg_prod(neg_prod), .rnd_mode(rnd_mode),
        .byp_valid(byp_valid), .byp_result(byp_result),
        .flag_invalid(flag_invalid)
    );

    function automatic logic [63:0] pool(input int i);
        case (i)
            0:  return 64'h0000_0000_0000_0000; // +0
            1:  return 64'h8000_0000_0000_0000; // -0
            2:  return 64'h3FF8_0000_0000_0000; // +1.5
            3:  return 64'hC000_0000_0000_0000; // -2
            4:  return 64'h0000_0000_0000_0123; // +subnormal
            5:  return 64'h800F_FFFF_FFFF_FFFF; // -subnormal
            6:  return 64'h7FF0_0000_0000_0000; // +inf
            7:  return 64'hFFF0_0000_0000_0000; // -inf
            8:  return 64'h7FF8_0000_0000_0001; // +qnan
            9:  return 64'hFFFC_0000_0000_00AB; // -qnan
            10: return 64'h7FF0_0000_0000_0005; // +snan
            default: return 64'hFFF4_0000_0000_0C00; // -snan
        endcase
    endfunction

    function automatic bit f_nan(input logic [63:0] w);
        return (w[62:52] == 11'h7FF) && (w[51:0] != 0);
    endfunction
    function automatic bit f_snan(input logic [63:0] w);
        return f_nan(w) && !w[51];
    endfunction
    function automatic bit f_inf(input logic [63:0] w);
        return (w[62:52] == 11'h7FF) && (w[51:0] == 0);
    endfunction
    function automatic bit f_zero(input logic [63:0] w);
        return w[62:0] == 0;
    endfunction

    task automatic model(input logic [63:0] z, x, y, input logic n, input logic [1:0] rm,
                         output logic bv, output logic [63:0] r, output logic inv,
                         output string tag);
        logic [63:0] ops [3];
        logic        ps;
        logic [63:0] dn;
        ops[0] = z; ops[1] = x; ops[2] = y;
        dn = 64'h7FF8_0000_0000_0000;
        bv = 1'b1; inv = 1'b0; r = 64'd0; tag = "";
        ps = x[63] ^ y[63] ^ n; // R4
        for (int k = 2; k >= 0; k--)
            if (f_nan(ops[k]) && !f_snan(ops[k])) begin r = ops[k]; tag = "R2"; end
        for (int k = 2; k >= 0; k--)
            if (f_snan(ops[k])) begin r = ops[k] | 64'h0008_0000_0000_0000; inv = 1'b1; tag = "R1"; end
        if (tag != "") return;
        if ((f_inf(x) && f_zero(y)) || (f_zero(x) && f_inf(y))) begin
            r = dn; inv = 1'b1; tag = "R3";
        end else if (f_inf(x) || f_inf(y)) begin
            if (f_inf(z) && z[63] != ps) begin r = dn; inv = 1'b1; tag = "R5"; end
            else begin r = {ps, 11'h7FF, 52'd0}; tag = "R6"; end
        end else if (f_inf(z)) begin
            r = z; tag = "R7";
        end else if (f_zero(x) || f_zero(y)) begin
            if (f_zero(z) && z[63] == ps) begin r = z; tag = "R8"; end
            else if (f_zero(z)) begin r = {(rm == 2'b11), 63'd0}; tag = "R9"; end
            else begin r = z; tag = "R10"; end
        end else begin
            bv = 1'b0; tag = "R11";
        end
    endtask

    task automatic apply(input logic [63:0] z, x, y, input logic n, input logic [1:0] rm);
        logic        e_bv, e_inv;
        logic [63:0] e_r;
        string       tag;
        @(negedge clk);
        op_z = z; op_x = x; op_y = y; neg_prod = n; rnd_mode = rm;
        #(CLK_PERIOD/4);
        model(z, x, y, n, rm, e_bv, e_r, e_inv, tag);
        n_vec++;
        if (byp_valid !== e_bv || byp_result !== e_r || flag_invalid !== e_inv) begin
            n_fail++;
            $display("FAIL %s z=%h x=%h y=%h n=%0b rm=%0d : got v=%0b r=%h i=%0b exp v=%0b r=%h i=%0b",
                     tag, z, x, y, n, rm, byp_valid, byp_result, flag_invalid, e_bv, e_r, e_inv);
        end
        // R12: invalid only with bypass
        if (flag_invalid && !byp_valid) begin
            n_fail++;
            $display("FAIL R12 got invalid=1 bypass=0 exp bypass=1");
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WD_LIMIT && !done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog got %0d cycles exp <= %0d", cycles, WD_LIMIT);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        op_z = '0; op_x = '0; op_y = '0; neg_prod = 1'b0; rnd_mode = 2'b00;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // reset-state / all-zero inputs: R8 gives +0
        apply(64'd0, 64'd0, 64'd0, 1'b0, 2'b00);
        // R9 directed: +0 - (+0*+0) under round-down gives -0
        apply(64'd0, 64'd0, 64'd0, 1'b1, 2'b11);
        // R5 directed: +inf + (+inf * -2)
        apply(64'h7FF0_0000_0000_0000, 64'h7FF0_0000_0000_0000, 64'hC000_0000_0000_0000, 1'b0, 2'b00);
        // R1 precedence: snan in y beats qnan in z
        apply(64'h7FF8_0000_0000_0001, 64'h3FF8_0000_0000_0000, 64'h7FF0_0000_0000_0005, 1'b0, 2'b01);
        // full sweep: R1..R12
        for (int a = 0; a < N_VALS; a++)
            for (int b = 0; b < N_VALS; b++)
                for (int c = 0; c < N_VALS; c++)
                    for (int m = 0; m < 8; m++)
                        apply(pool(a), pool(b), pool(c), m[2], m[1:0]);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule